// File: doc/BRIEF.md
# Floppy Controller Host Register Block

This block is the processor-facing register file of a floppy disk controller model. A host reaches four byte registers through a strobe with address bits 2:1. On reads, index 0 is the status register. On writes, index 0 is the command register. Index 1 holds the track number, index 2 the sector number, and index 3 is the data port. Behind the data port sits a sector buffer with a position pointer and a fill length. Busy and data-request are not kept as stored flags. They are worked out on every access from whether the pointer is still below the length.

A read-class command empties the buffer, which a disk-side load port then fills one byte at a time. A write-class command opens a sector-sized window, and the host fills it through the data port. The disk side reads those bytes back through a media read port. Interrupts are kept as a level latch plus a "fresh" edge flag. An interrupt is raised by the host touching the final buffered byte, by a command that finishes at once, or by a command rejected because no drive is ready. The data-request output is meant to pace an external DMA engine.

Top module: `fdc_hostregs`

## Requirements
- R1: After reset, irq, irq_edge and dma_req are 0, the status register reads 0x00 and the data port reads 0xFF.
- R2: bus_addr[2:1] selects the register. Index 1 (track) and index 2 (sector) read back the last byte written to them. Index 0 is command on write and status on read. Index 3 is the data port.
- R3: After a read-class or write-class command, status bits 1 and 0 both read 1 while pointer < length, and dma_req equals that same condition. Status bits 7:2 come from the stored status.
- R4: After a motion command (code bits 7:4 in 0x0..0x7), bit 0 of status reads (pointer < length), the other bits come from the stored status (0x00), and dma_req is 0.
- R5: A data-port read returns the byte at the pointer and advances the pointer. When pointer >= length, it returns 0xFF and the pointer stays where it is.
- R6: A data-port write while pointer < length stores the byte at the pointer and advances the pointer, which the media port shows. When the buffer is exhausted, the write is ignored.
- R7: A read or write of the data port while pointer = length-1 raises the interrupt from the next cycle.
- R8: Raising the interrupt sets the level latch. The edge flag is set only if the level was clear, and otherwise keeps its value. irq_edge never reads 1 while irq is 0.
- R9: A status read clears both irq and irq_edge from the next cycle.
- R10: A command write clears any pending interrupt. Read-class codes (bits 7:4 = 0x8, 0x9, 0xC, 0xE) with the drive ready leave irq at 0 and an empty buffer. Motion codes raise irq and irq_edge.
- R11: A read-class or write-class command with drive_ready low sets stored status 0x80, empties the buffer and raises the interrupt.
- R12: Force-interrupt (bits 7:4 = 0xD) empties the buffer, sets status 0x00 and raises irq with irq_edge.
- R13: A write-class command (bits 7:4 = 0xA, 0xB, 0xF) with the drive ready sets pointer 0 and length SECTOR_BYTES. The load port appends bytes at the length until it reaches DEPTH, and further loads are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index (host address bits 2:1) |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid in the access cycle |
| drive_ready | input | 1 | Drive present and ready |
| ld_valid | input | 1 | Disk-side byte load strobe |
| ld_data | input | 8 | Byte appended to the buffer |
| med_addr | input | $clog2(DEPTH) | Media-side buffer read index |
| med_rdata | output | 8 | Buffer byte at med_addr |
| irq | output | 1 | Interrupt level latch |
| irq_edge | output | 1 | Fresh-interrupt flag |
| dma_req | output | 1 | Data request for a DMA engine |

## Verification
The properties assume a single host access per cycle, chosen by bus_req and bus_wr, with bus_addr and bus_wdata stable during it. They also assume drive_ready is steady across a command write. The bench holds each access for exactly one clock and leaves an idle cycle before the next. It changes drive_ready only between commands and drives the load port only when no command write is in flight. So a command restart never meets a same-cycle load, and no status read lands in the same cycle as an interrupt source.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        IDX_CMDSTAT = 2'd0,
        IDX_TRACK   = 2'd1,
        IDX_SECTOR  = 2'd2,
        IDX_DATA    = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        CK_MOTION,
        CK_READ,
        CK_WRITE,
        CK_ABORT
    } cmd_kind_e;

    localparam logic [BYTE_W-1:0] ST_IDLE      = 8'h00;
    localparam logic [BYTE_W-1:0] ST_NOT_READY = 8'h80;
    localparam logic [BYTE_W-1:0] EMPTY_BYTE   = 8'hFF;
    localparam logic [BYTE_W-1:0] MASK_DRQ_CMD = 8'hFC;
    localparam logic [BYTE_W-1:0] MASK_PLAIN   = 8'hFE;

    typedef struct packed {
        logic level;
        logic fresh;
    } irq_state_t;

    typedef struct packed {
        logic cmd_wr;
        logic stat_rd;
        logic trk_wr;
        logic sec_wr;
        logic dat_rd;
        logic dat_wr;
    } host_strobe_t;

    function automatic cmd_kind_e classify_cmd(input logic [BYTE_W-1:0] code);
        cmd_kind_e k;
        case (code[7:4])
            4'h8, 4'h9, 4'hC, 4'hE: k = CK_READ;
            4'hA, 4'hB, 4'hF:       k = CK_WRITE;
            4'hD:                   k = CK_ABORT;
            default:                k = CK_MOTION;
        endcase
        return k;
    endfunction

    function automatic logic [BYTE_W-1:0] status_view(
        input logic [BYTE_W-1:0] stored,
        input logic              drq_mode,
        input logic              avail
    );
        logic [BYTE_W-1:0] v;
        if (drq_mode) v = (stored & MASK_DRQ_CMD) | {6'b0, avail, avail};
        else          v = (stored & MASK_PLAIN)   | {7'b0, avail};
        return v;
    endfunction

    function automatic irq_state_t irq_next(
        input irq_state_t cur,
        input logic       clr,
        input logic       raise
    );
        irq_state_t n;
        n = cur;
        if (clr) n = '0;
        if (raise) begin
            if (!n.level) n.fresh = 1'b1;
            n.level = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/fdc_host_decode.sv
module fdc_host_decode
    import fdc_pkg::*;
(
    input  logic         bus_req,
    input  logic         bus_wr,
    input  logic [2:1]   bus_addr,
    output host_strobe_t strb
);
    reg_idx_e idx;
    logic     rd, wr;

    always_comb begin
        idx = reg_idx_e'(bus_addr);
        rd  = bus_req & ~bus_wr;
        wr  = bus_req &  bus_wr;
        strb.cmd_wr  = wr & (idx == IDX_CMDSTAT);
        strb.stat_rd = rd & (idx == IDX_CMDSTAT);
        strb.trk_wr  = wr & (idx == IDX_TRACK);
        strb.sec_wr  = wr & (idx == IDX_SECTOR);
        strb.dat_rd  = rd & (idx == IDX_DATA);
        strb.dat_wr  = wr & (idx == IDX_DATA);
    end
endmodule

// File: rtl/fdc_secbuf.sv
module fdc_secbuf
    import fdc_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic [PTR_W-1:0]         restart_len,
    input  logic                     take,
    input  logic                     put,
    input  logic [BYTE_W-1:0]        put_byte,
    input  logic                     ld_valid,
    input  logic [BYTE_W-1:0]        ld_data,
    input  logic [$clog2(DEPTH)-1:0] med_addr,
    output logic [BYTE_W-1:0]        med_rdata,
    output logic [PTR_W-1:0]         ptr,
    output logic [PTR_W-1:0]         len,
    output logic                     avail,
    output logic [BYTE_W-1:0]        cur_byte,
    output logic                     final_touch
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              room;
    logic              step;

    assign avail       = (ptr < len);
    assign room        = (len < FULL);
    assign step        = (take | put) & avail;
    assign cur_byte    = mem[ptr[IDX_W-1:0]];
    assign med_rdata   = mem[med_addr];
    assign final_touch = step & (ptr == len - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            len <= '0;
        end else if (restart) begin
            ptr <= '0;
            len <= restart_len;
        end else begin
            if (step)             ptr <= ptr + ONE;
            if (ld_valid && room) len <= len + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!restart) begin
            if (put && avail)     mem[ptr[IDX_W-1:0]] <= put_byte;
            if (ld_valid && room) mem[len[IDX_W-1:0]] <= ld_data;
        end
    end
endmodule

// File: rtl/fdc_irq_latch.sv
module fdc_irq_latch
    import fdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       raise,
    output irq_state_t st
);
    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= irq_next(st, clr, raise);
    end
endmodule

// File: rtl/fdc_cmd_ctrl.sv
module fdc_cmd_ctrl
    import fdc_pkg::*;
#(
    parameter int PTR_W        = 10,
    parameter int SECTOR_BYTES = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  host_strobe_t       strb,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               drive_ready,
    output logic [BYTE_W-1:0]  stored_status,
    output logic               drq_mode,
    output logic [BYTE_W-1:0]  track,
    output logic [BYTE_W-1:0]  sector,
    output logic               buf_restart,
    output logic [PTR_W-1:0]   restart_len,
    output logic               raise
);
    localparam logic [PTR_W-1:0] SEC_LEN = PTR_W'(SECTOR_BYTES);

    cmd_kind_e         kind;
    logic [BYTE_W-1:0] st_next;
    logic              drq_next;

    always_comb begin
        kind        = classify_cmd(wdata);
        st_next     = stored_status;
        drq_next    = drq_mode;
        buf_restart = 1'b0;
        restart_len = '0;
        raise       = 1'b0;
        if (strb.cmd_wr) begin
            case (kind)
                CK_MOTION: begin
                    st_next  = ST_IDLE;
                    drq_next = 1'b0;
                    raise    = 1'b1;
                end
                CK_READ, CK_WRITE: begin
                    drq_next    = 1'b1;
                    buf_restart = 1'b1;
                    if (drive_ready) begin
                        st_next = ST_IDLE;
                        if (kind == CK_WRITE) restart_len = SEC_LEN;
                    end else begin
                        st_next = ST_NOT_READY;
                        raise   = 1'b1;
                    end
                end
                default: begin
                    st_next     = ST_IDLE;
                    drq_next    = 1'b1;
                    buf_restart = 1'b1;
                    raise       = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_status <= ST_IDLE;
            drq_mode      <= 1'b0;
            track         <= '0;
            sector        <= '0;
        end else begin
            stored_status <= st_next;
            drq_mode      <= drq_next;
            if (strb.trk_wr) track  <= wdata;
            if (strb.sec_wr) sector <= wdata;
        end
    end
endmodule

// File: rtl/fdc_hostregs.sv
module fdc_hostregs
    import fdc_pkg::*;
#(
    parameter int DEPTH        = 512,
    parameter int SECTOR_BYTES = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_req,
    input  logic                     bus_wr,
    input  logic [2:1]               bus_addr,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    input  logic                     drive_ready,
    input  logic                     ld_valid,
    input  logic [7:0]               ld_data,
    input  logic [$clog2(DEPTH)-1:0] med_addr,
    output logic [7:0]               med_rdata,
    output logic                     irq,
    output logic                     irq_edge,
    output logic                     dma_req
);
    localparam int PTR_W = $clog2(DEPTH) + 1;

    host_strobe_t      strb;
    logic              cmd_wr, stat_rd, dat_rd, dat_wr;
    logic [7:0]        wdata;
    logic [7:0]        stored_status, track, sector, cur_byte;
    logic              drq_mode, buf_restart, raise_cmd, final_touch, avail;
    logic [PTR_W-1:0]  restart_len, buf_ptr, buf_len;
    irq_state_t        irq_st;

    fdc_host_decode u_dec (
        .bus_req (bus_req),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .strb    (strb)
    );

    assign cmd_wr  = strb.cmd_wr;
    assign stat_rd = strb.stat_rd;
    assign dat_rd  = strb.dat_rd;
    assign dat_wr  = strb.dat_wr;
    assign wdata   = bus_wdata;

    fdc_cmd_ctrl #(.PTR_W(PTR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_cmd (
        .clk          (clk),
        .rst          (rst),
        .strb         (strb),
        .wdata        (wdata),
        .drive_ready  (drive_ready),
        .stored_status(stored_status),
        .drq_mode     (drq_mode),
        .track        (track),
        .sector       (sector),
        .buf_restart  (buf_restart),
        .restart_len  (restart_len),
        .raise        (raise_cmd)
    );

    fdc_secbuf #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .restart    (buf_restart),
        .restart_len(restart_len),
        .take       (dat_rd),
        .put        (dat_wr),
        .put_byte   (wdata),
        .ld_valid   (ld_valid),
        .ld_data    (ld_data),
        .med_addr   (med_addr),
        .med_rdata  (med_rdata),
        .ptr        (buf_ptr),
        .len        (buf_len),
        .avail      (avail),
        .cur_byte   (cur_byte),
        .final_touch(final_touch)
    );

    fdc_irq_latch u_irq (
        .clk  (clk),
        .rst  (rst),
        .clr  (stat_rd | cmd_wr),
        .raise(raise_cmd | final_touch),
        .st   (irq_st)
    );

    assign irq      = irq_st.level;
    assign irq_edge = irq_st.fresh;
    assign dma_req  = drq_mode & avail;

    always_comb begin
        case (reg_idx_e'(bus_addr))
            IDX_CMDSTAT: bus_rdata = status_view(stored_status, drq_mode, avail);
            IDX_TRACK:   bus_rdata = track;
            IDX_SECTOR:  bus_rdata = sector;
            default:     bus_rdata = avail ? cur_byte : EMPTY_BYTE;
        endcase
    end
endmodule

// File: rtl/fdc_hostregs_chk.sv
module fdc_hostregs_chk #(
    parameter int PTR_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_wr,
    input logic             stat_rd,
    input logic             dat_rd,
    input logic             dat_wr,
    input logic [7:0]       wdata,
    input logic             drive_ready,
    input logic [PTR_W-1:0] buf_ptr,
    input logic [PTR_W-1:0] buf_len,
    input logic [7:0]       bus_rdata,
    input logic             irq,
    input logic             irq_edge,
    input logic             dma_req
);
    AST_EDGE_WITH_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_edge |-> irq);  // R8

    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (!irq && !irq_edge));  // R9

    AST_DRQ_IN_STATUS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && dma_req) |-> (bus_rdata[1:0] == 2'b11));  // R3

    AST_EMPTY_DATA_FF: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && (buf_ptr >= buf_len)) |-> (bus_rdata == 8'hFF));  // R5

    AST_PTR_WITHIN_LEN: assert property (@(posedge clk) disable iff (rst)
        buf_ptr <= buf_len);  // R5

    AST_FINAL_BYTE_RAISES: assert property (@(posedge clk) disable iff (rst)
        ((dat_rd || dat_wr) && (buf_len != '0) && (buf_ptr == buf_len - PTR_W'(1))) |=> irq);  // R7

    AST_READ_CMD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (wdata[7:4] == 4'h8) && drive_ready) |=> (!irq && (buf_len == '0)));  // R10

    AST_ABORT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (wdata[7:4] == 4'hD)) |=> (irq && irq_edge && (buf_len == '0)));  // R12

    AST_NOT_READY_RAISES: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[7] && (wdata[7:4] != 4'hD) && !drive_ready) |=> (irq && (buf_len == '0)));  // R11
endmodule

bind fdc_hostregs fdc_hostregs_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .stat_rd    (stat_rd),
    .dat_rd     (dat_rd),
    .dat_wr     (dat_wr),
    .wdata      (wdata),
    .drive_ready(drive_ready),
    .buf_ptr    (buf_ptr),
    .buf_len    (buf_len),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .irq_edge   (irq_edge),
    .dma_req    (dma_req)
);

// File: tb/tb_fdc_hostregs.sv
module tb_fdc_hostregs;
    localparam int DEPTH  = 512;
    localparam int SECTOR = 256;
    localparam int IDX_W  = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_req = 1'b0, bus_wr = 1'b0;
    logic [2:1]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic             drive_ready = 1'b1;
    logic             ld_valid = 1'b0;
    logic [7:0]       ld_data = '0;
    logic [IDX_W-1:0] med_addr = '0;
    logic [7:0]       med_rdata;
    logic             irq, irq_edge, dma_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fdc_hostregs #(.DEPTH(DEPTH), .SECTOR_BYTES(SECTOR)) dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .drive_ready(drive_ready), .ld_valid(ld_valid), .ld_data(ld_data),
        .med_addr(med_addr), .med_rdata(med_rdata), .irq(irq),
        .irq_edge(irq_edge), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = idx; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] idx, output logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = idx;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic load(input logic [7:0] b);
        @(negedge clk);
        ld_valid = 1'b1; ld_data = b;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq after reset", irq, 0);
        chk("R1 irq_edge after reset", irq_edge, 0);
        chk("R1 dma_req after reset", dma_req, 0);
        host_rd(2'd0, d); chk("R1 status after reset", d, 8'h00);
        host_rd(2'd3, d); chk("R1 data port empty", d, 8'hFF);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        host_wr(2'd1, 8'h5A);
        host_wr(2'd2, 8'h03);
        host_rd(2'd1, d); chk("R2 track readback", d, 8'h5A);
        host_rd(2'd2, d); chk("R2 sector readback", d, 8'h03);
        host_rd(2'd0, d); chk("R2 status index untouched", d, 8'h00);
    endtask

    task automatic t_motion();
        logic [7:0] d;
        host_wr(2'd0, 8'h10);
        chk("R10 motion raises irq", irq, 1);
        chk("R10 motion raises edge", irq_edge, 1);
        host_rd(2'd0, d); chk("R4 status after motion", d, 8'h00);
        chk("R9 status read clears irq", irq, 0);
        chk("R9 status read clears edge", irq_edge, 0);
        load(8'h11); load(8'h22);
        host_rd(2'd0, d); chk("R4 busy only in plain mode", d, 8'h01);
        chk("R4 no dma_req in plain mode", dma_req, 0);
    endtask

    task automatic t_read_flow();
        logic [7:0] d;
        host_wr(2'd0, 8'h88);
        chk("R10 read cmd leaves irq clear", irq, 0);
        chk("R3 dma_req on empty buffer", dma_req, 0);
        host_rd(2'd0, d); chk("R3 status empty", d, 8'h00);
        load(8'hA1); load(8'hB2); load(8'hC3);
        chk("R3 dma_req with data", dma_req, 1);
        host_rd(2'd0, d); chk("R3 status with data", d, 8'h03);
        host_rd(2'd3, d); chk("R5 first byte", d, 8'hA1);
        host_rd(2'd3, d); chk("R5 second byte", d, 8'hB2);
        chk("R7 no irq before final byte", irq, 0);
        host_rd(2'd3, d); chk("R5 third byte", d, 8'hC3);
        chk("R7 final read raises irq", irq, 1);
        chk("R8 fresh edge on first raise", irq_edge, 1);
        host_rd(2'd3, d); chk("R5 exhausted read", d, 8'hFF);
        chk("R3 dma_req drops at end", dma_req, 0);
        load(8'hD4);
        host_rd(2'd3, d); chk("R5 pointer held on exhausted read", d, 8'hD4);
        chk("R8 level kept on second raise", irq, 1);
        chk("R8 edge kept on second raise", irq_edge, 1);
        host_wr(2'd0, 8'h8C);
        chk("R10 command write clears pending irq", irq, 0);
        chk("R10 command write clears edge", irq_edge, 0);
    endtask

    task automatic t_write_flow();
        logic [7:0] d;
        host_wr(2'd0, 8'hA8);
        chk("R13 write cmd opens window", dma_req, 1);
        host_rd(2'd0, d); chk("R3 status during write", d, 8'h03);
        for (int i = 0; i < SECTOR; i++) begin
            host_wr(2'd3, 8'(i ^ 8'h5A));
            if (i == SECTOR - 2) chk("R7 no irq before final write", irq, 0);
        end
        chk("R7 final write raises irq", irq, 1);
        chk("R13 window closed", dma_req, 0);
        host_wr(2'd3, 8'h77);
        med_addr = 9'd0;   #1 chk("R6 media byte 0", med_rdata, 8'h5A);
        med_addr = 9'd100; #1 chk("R6 media byte 100", med_rdata, 8'(100 ^ 8'h5A));
        med_addr = 9'd255; #1 chk("R6 media byte 255", med_rdata, 8'(255 ^ 8'h5A));
        med_addr = 9'd256; #1 chk("R6 write past end ignored", (med_rdata == 8'h77), 0);
        host_rd(2'd0, d); chk("R3 status after write done", d, 8'h00);
    endtask

    task automatic t_not_ready();
        logic [7:0] d;
        drive_ready = 1'b0;
        host_wr(2'd0, 8'h80);
        chk("R11 not ready raises irq", irq, 1);
        host_rd(2'd0, d); chk("R11 not-ready status", d, 8'h80);
        host_wr(2'd0, 8'hA0);
        chk("R11 write not ready raises irq", irq, 1);
        chk("R11 no dma_req when not ready", dma_req, 0);
        host_rd(2'd3, d); chk("R11 buffer empty", d, 8'hFF);
        host_rd(2'd0, d); chk("R11 status after write cmd", d, 8'h80);
        drive_ready = 1'b1;
    endtask

    task automatic t_abort();
        logic [7:0] d;
        host_wr(2'd0, 8'h88);
        load(8'h01); load(8'h02);
        chk("R12 data before abort", dma_req, 1);
        host_wr(2'd0, 8'hD0);
        chk("R12 abort raises irq", irq, 1);
        chk("R12 abort raises edge", irq_edge, 1);
        chk("R12 abort drops dma_req", dma_req, 0);
        host_rd(2'd0, d); chk("R12 status after abort", d, 8'h00);
        host_rd(2'd3, d); chk("R12 buffer emptied", d, 8'hFF);
    endtask

    task automatic t_full();
        logic [7:0] d;
        host_wr(2'd0, 8'h88);
        for (int i = 0; i < DEPTH; i++) load(8'(i));
        load(8'hEE);
        host_rd(2'd0, d); chk("R13 status full buffer", d, 8'h03);
        host_rd(2'd3, d); chk("R13 first byte kept after overflow load", d, 8'h00);
        for (int i = 1; i < DEPTH; i++) host_rd(2'd3, d);
        chk("R13 last stored byte", d, 8'hFF);
        chk("R7 irq at final byte of full buffer", irq, 1);
        load(8'hEE);
        host_rd(2'd3, d); chk("R13 load beyond depth dropped", d, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_motion();
        t_read_flow();
        t_write_flow();
        t_not_ready();
        t_abort();
        t_full();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL timeout R1..all actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule